// File: doc/BRIEF.md
# Extended Mode Register Programming Sequencer

This block sits on the controller side of a DDR2-style SDRAM interface and programs the first extended mode register. A requester presents the wanted settings and pulses a request. The settings are DLL enable, half-strength output drive, on-die termination value, additive latency, off-chip driver calibration control and the disable for the complementary data strobe. The block packs these into the address bus. It launches the register-write command only on an edge where every bank is precharged and the clock enable is high, and then holds off any further write until the command cycle time has passed. A single pending slot absorbs one request that arrives while a write is still being spaced out.

The block also decides when read commands may be issued. The register has no defined value after power-up, so a ready flag stays low until the first write has been spaced out. Each time the DLL becomes enabled, either by a register write or on leaving self-refresh, read permission is withheld for a fixed number of clocks while the DLL locks. In every cycle without a write, the command pins carry a no-operation encoding.

Top module: `ext_mode_prog`

## Requirements
- R1: In every cycle without a register write, the pins show the no-operation code: cs_n_o=0, ras_n_o=1, cas_n_o=1, we_n_o=1, ba_o=0 and addr_o=0.
- R2: A register write shows cs_n_o, ras_n_o, cas_n_o and we_n_o all 0 with ba_o=2'b01, for exactly one cycle.
- R3: During a write, addr_o[0] is the inverse of the DLL enable (0 enables). addr_o[1] is half drive. addr_o[2] is odt bit 0 and addr_o[6] is odt bit 1. addr_o[5:3] is the additive latency, addr_o[9:7] is the calibration control, addr_o[10] is the strobe disable, and addr_o[12:11] is 0.
- R4: A pending write is launched only at a clock edge where banks_idle_i and cke_i are both high; otherwise it stays pending. A request captured at one edge can be launched at the next edge at the earliest.
- R5: Two write cycles on the pins are at least TMRD cycles apart (default 2).
- R6: req_i is captured when no request is pending, and is discarded while one is pending. busy_o is high while a request is pending, and also in any cycle whose following edge still falls inside the spacing window.
- R7: ready_o is low from reset and rises TMRD cycles after the first write appears on the pins. It then stays high until reset.
- R8: After a write that enables the DLL, rd_ok_o is low for LOCK_CYC cycles (default 200) starting with the write cycle. It is high afterwards while ready_o is high and the part is not in self-refresh.
- R9: A write that disables the DLL drops rd_ok_o in the write cycle, and rd_ok_o stays low until a later write enables the DLL.
- R10: sr_enter_i drops rd_ok_o from the next cycle. sr_exit_i during self-refresh, with the DLL configured on, restarts the LOCK_CYC-cycle lockout from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-cycle request to write the register |
| dll_en_i | input | 1 | 1 = DLL enabled |
| half_drive_i | input | 1 | 1 = half-strength output driver |
| odt_sel_i | input | 2 | Termination value code |
| add_lat_i | input | 3 | Additive latency |
| ocd_i | input | 3 | Driver calibration control |
| strobe_n_off_i | input | 1 | 1 = complementary strobe disabled |
| banks_idle_i | input | 1 | All banks are precharged |
| cke_i | input | 1 | Clock enable currently high |
| sr_enter_i | input | 1 | Pulse: self-refresh entered |
| sr_exit_i | input | 1 | Pulse: self-refresh exited |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | 13 | Address bus |
| busy_o | output | 1 | Request pending or spacing active |
| ready_o | output | 1 | Register written at least once |
| rd_ok_o | output | 1 | Read commands permitted |

## Verification
The assertions assume that self-refresh entry and exit pulses arrive in a sensible order. They also assume that an exit pulse never falls on the same edge as a register write, because the order of the two lockout sources is not defined for that case. The stimulus changes inputs only just after a rising edge. It issues self-refresh events only while no request is pending and no spacing window is open. It also varies banks_idle_i and cke_i independently, so that held requests and request bursts arriving during the spacing window are both exercised.

// File: rtl/ext_mode_pkg.sv
package ext_mode_pkg;

  localparam int ADDR_W = 13;
  localparam int BANK_W = 2;

  typedef struct packed {
    logic       dll_en;
    logic       half_drive;
    logic [1:0] odt;
    logic [2:0] add_lat;
    logic [2:0] ocd;
    logic       strobe_n_off;
  } emr_cfg_t;

  typedef enum logic {
    CMD_NOP = 1'b0,
    CMD_EMR = 1'b1
  } cmd_kind_e;

  // Scatter the settings over the address bus; the bit positions are decoded by the memory.
  function automatic logic [ADDR_W-1:0] pack_emr(input emr_cfg_t c);
    logic [ADDR_W-1:0] w;
    w       = '0;
    w[0]    = ~c.dll_en;
    w[1]    = c.half_drive;
    w[2]    = c.odt[0];
    w[5:3]  = c.add_lat;
    w[6]    = c.odt[1];
    w[9:7]  = c.ocd;
    w[10]   = c.strobe_n_off;
    return w;
  endfunction

  // Width of a down-counter that must hold the value n.
  function automatic int cnt_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/emp_req_slot.sv
module emp_req_slot
  import ext_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_i,
  input  emr_cfg_t cfg_i,
  input  logic     take_i,
  output logic     pend_v_o,
  output emr_cfg_t pend_cfg_o
);

  logic     pend_v_q;
  emr_cfg_t pend_cfg_q;
  logic     accept_w;

  assign accept_w = req_i && !pend_v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q   <= 1'b0;
      pend_cfg_q <= '0;
    end else begin
      if (take_i) begin
        pend_v_q <= 1'b0;
      end
      if (accept_w) begin
        pend_v_q   <= 1'b1;
        pend_cfg_q <= cfg_i;
      end
    end
  end

  assign pend_v_o   = pend_v_q;
  assign pend_cfg_o = pend_cfg_q;

  // R6
  take_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> pend_v_o);

  // R6
  held_cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v_o && !take_i) |=> (pend_v_o && $stable(pend_cfg_o)));

endmodule

// File: rtl/emp_gap_timer.sv
module emp_gap_timer
  import ext_mode_pkg::*;
#(
  parameter int TMRD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic clear_o,
  output logic open_o
);

  localparam int CW = cnt_width(TMRD);
  localparam logic [CW-1:0] RELOAD = CW'(TMRD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= RELOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign clear_o = (cnt_q == '0);
  assign open_o  = !clear_o;

  // R5
  no_start_in_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> clear_o);

endmodule

// File: rtl/emp_lock_timer.sv
module emp_lock_timer
  import ext_mode_pkg::*;
#(
  parameter int LOCK_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic locked_o
);

  localparam int LW = cnt_width(LOCK_CYC);
  localparam logic [LW-1:0] FULL = LW'(LOCK_CYC);

  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= FULL;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign locked_o = (cnt_q != '0);

  // R8
  load_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> locked_o);

  // R8
  lock_only_counts_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !locked_o) |=> !locked_o);

endmodule

// File: rtl/emp_cmd_drive.sv
module emp_cmd_drive
  import ext_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic [ADDR_W-1:0] word_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ADDR_W-1:0] addr_o
);

  cmd_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= CMD_NOP;
      addr_q <= '0;
    end else if (fire_i) begin
      kind_q <= CMD_EMR;
      addr_q <= word_i;
    end else begin
      kind_q <= CMD_NOP;
      addr_q <= '0;
    end
  end

  logic is_emr_w;
  assign is_emr_w = (kind_q == CMD_EMR);

  assign cs_n_o  = 1'b0;
  assign ras_n_o = !is_emr_w;
  assign cas_n_o = !is_emr_w;
  assign we_n_o  = !is_emr_w;
  assign ba_o    = is_emr_w ? BANK_W'(1) : '0;
  assign addr_o  = addr_q;

  // R2
  write_follows_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_o |-> $past(fire_i));

  // R2
  single_cycle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n_o && !fire_i) |=> we_n_o);

endmodule

// File: rtl/ext_mode_prog.sv
module ext_mode_prog
  import ext_mode_pkg::*;
#(
  parameter int TMRD     = 2,
  parameter int LOCK_CYC = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  logic        dll_en_i,
  input  logic        half_drive_i,
  input  logic [1:0]  odt_sel_i,
  input  logic [2:0]  add_lat_i,
  input  logic [2:0]  ocd_i,
  input  logic        strobe_n_off_i,
  input  logic        banks_idle_i,
  input  logic        cke_i,
  input  logic        sr_enter_i,
  input  logic        sr_exit_i,
  output logic        cs_n_o,
  output logic        ras_n_o,
  output logic        cas_n_o,
  output logic        we_n_o,
  output logic [1:0]  ba_o,
  output logic [12:0] addr_o,
  output logic        busy_o,
  output logic        ready_o,
  output logic        rd_ok_o
);

  localparam int SW = cnt_width(TMRD);

  emr_cfg_t req_cfg_w;
  emr_cfg_t pend_cfg_w;
  logic     pend_v_w;
  logic     gap_clear_w;
  logic     gap_open_w;
  logic     issue_w;
  logic     lock_load_w;
  logic     locked_w;

  logic dll_cfg_q;
  logic in_sr_q;
  logic seen_wr_q;
  logic ready_q;

  assign req_cfg_w = '{dll_en:       dll_en_i,
                       half_drive:   half_drive_i,
                       odt:          odt_sel_i,
                       add_lat:      add_lat_i,
                       ocd:          ocd_i,
                       strobe_n_off: strobe_n_off_i};

  emp_req_slot u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .cfg_i      (req_cfg_w),
    .take_i     (issue_w),
    .pend_v_o   (pend_v_w),
    .pend_cfg_o (pend_cfg_w)
  );

  assign issue_w = pend_v_w && gap_clear_w && banks_idle_i && cke_i;

  emp_gap_timer #(.TMRD(TMRD)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (issue_w),
    .clear_o (gap_clear_w),
    .open_o  (gap_open_w)
  );

  emp_cmd_drive u_drv (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (issue_w),
    .word_i  (pack_emr(pend_cfg_w)),
    .cs_n_o  (cs_n_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o),
    .ba_o    (ba_o),
    .addr_o  (addr_o)
  );

  // DLL becomes enabled by a write, or by leaving self-refresh with it configured on.
  assign lock_load_w = (issue_w && pend_cfg_w.dll_en) ||
                       (sr_exit_i && in_sr_q && dll_cfg_q);

  emp_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (lock_load_w),
    .locked_o (locked_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dll_cfg_q <= 1'b0;
      in_sr_q   <= 1'b0;
      seen_wr_q <= 1'b0;
      ready_q   <= 1'b0;
    end else begin
      if (issue_w) begin
        dll_cfg_q <= pend_cfg_w.dll_en;
        seen_wr_q <= 1'b1;
      end
      if (sr_exit_i) begin
        in_sr_q <= 1'b0;
      end else if (sr_enter_i) begin
        in_sr_q <= 1'b1;
      end
      if (seen_wr_q && gap_clear_w) begin
        ready_q <= 1'b1;
      end
    end
  end

  assign busy_o  = pend_v_w || gap_open_w;
  assign ready_o = ready_q;
  assign rd_ok_o = ready_q && dll_cfg_q && !in_sr_q && !locked_w;

  // ---------------- checks ----------------
  logic          pins_wr_w;
  logic [SW-1:0] since_wr_q;

  assign pins_wr_w = !cs_n_o && !ras_n_o && !cas_n_o && !we_n_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_wr_q <= SW'(TMRD);
    end else if (pins_wr_w) begin
      since_wr_q <= SW'(1);
    end else if (since_wr_q < SW'(TMRD)) begin
      since_wr_q <= since_wr_q + 1'b1;
    end
  end

  // R5
  write_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pins_wr_w |-> (since_wr_q >= SW'(TMRD)));

  // R4
  precond_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pins_wr_w |-> $past(banks_idle_i && cke_i));

  // R3
  upper_bits_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pins_wr_w |-> (addr_o[12:11] == 2'b00 && ba_o == 2'b01));

  // R7
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);

  // R7
  rd_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok_o |-> ready_o);

  // R8
  enable_write_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_wr_w && !addr_o[0]) |-> !rd_ok_o);

  // R9
  disable_write_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_wr_w && addr_o[0]) |-> !rd_ok_o);

  // R10
  sr_entry_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_enter_i && !sr_exit_i) |=> !rd_ok_o);

endmodule

// File: tb/ext_mode_prog_tb.sv
module ext_mode_prog_tb;

  localparam int TMRD = 2;
  localparam int LOCK = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, dll_en = 1'b0, half = 1'b0, soff = 1'b0;
  logic [1:0]  odt = '0;
  logic [2:0]  lat = '0, ocd = '0;
  logic        banks_idle = 1'b1, cke = 1'b1, sr_enter = 1'b0, sr_exit = 1'b0;
  logic        cs_n, ras_n, cas_n, we_n, busy, ready, rd_ok;
  logic [1:0]  ba;
  logic [12:0] addr;

  always #5 clk = ~clk;

  ext_mode_prog #(.TMRD(TMRD), .LOCK_CYC(LOCK)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .dll_en_i(dll_en),
    .half_drive_i(half), .odt_sel_i(odt), .add_lat_i(lat), .ocd_i(ocd),
    .strobe_n_off_i(soff), .banks_idle_i(banks_idle), .cke_i(cke),
    .sr_enter_i(sr_enter), .sr_exit_i(sr_exit),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ba_o(ba), .addr_o(addr), .busy_o(busy), .ready_o(ready), .rd_ok_o(rd_ok)
  );

  // ---------------- behavioural reference ----------------
  int          n, last_wr, ready_at, lock_end;
  bit          q_full, q_dll, m_wr, cfg_dll, in_sr;
  logic [12:0] q_word, m_word;

  always @(posedge clk) begin
    bit fire, was_full, was_sr;
    if (!rst_n) begin
      n = 0; last_wr = -1000; ready_at = -1; lock_end = 0;
      q_full = 0; q_dll = 0; m_wr = 0; cfg_dll = 0; in_sr = 0;
      q_word = '0; m_word = '0;
    end else begin
      n++;
      was_full = q_full;
      was_sr   = in_sr;
      fire = q_full && (n - last_wr >= TMRD) && banks_idle && cke;
      m_wr = fire;
      if (fire) begin
        m_word  = q_word;
        last_wr = n;
        if (ready_at < 0) ready_at = n + TMRD;
        cfg_dll = q_dll;
        if (q_dll) lock_end = n + LOCK;
        q_full = 0;
      end
      if (req && !was_full) begin
        q_full = 1;
        q_dll  = dll_en;
        q_word = {2'b00, soff, ocd, odt[1], lat, odt[0], half, ~dll_en};
      end
      if (sr_exit) in_sr = 0;
      else if (sr_enter) in_sr = 1;
      if (sr_exit && was_sr && cfg_dll) lock_end = n + LOCK;
    end
  end

  // ---------------- comparison ----------------
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always @(negedge clk) begin
    bit e_ready, e_rd, e_busy;
    if (!done) begin
      vectors++;
      e_ready = (ready_at >= 0) && (n >= ready_at);
      e_rd    = e_ready && cfg_dll && !in_sr && (n >= lock_end);
      e_busy  = q_full || (n - last_wr < TMRD - 1);
      if (m_wr) begin
        if ({cs_n, ras_n, cas_n, we_n, ba} != 6'b0000_01) begin
          miscompares++;
          $display("FAIL R2/R4/R5 cyc %0d pins=%b exp=%b", n, {cs_n, ras_n, cas_n, we_n, ba}, 6'b000001);
        end
        if (addr !== m_word) begin
          miscompares++;
          $display("FAIL R3 cyc %0d addr=%h exp=%h", n, addr, m_word);
        end
      end else if ({cs_n, ras_n, cas_n, we_n, ba, addr} !== {4'b0111, 2'b00, 13'h0}) begin
        miscompares++;
        $display("FAIL R1 cyc %0d pins=%b ba=%b addr=%h exp=0111/00/0000", n, {cs_n, ras_n, cas_n, we_n}, ba, addr);
      end
      if (busy !== e_busy) begin
        miscompares++;
        $display("FAIL R6 cyc %0d busy=%b exp=%b", n, busy, e_busy);
      end
      if (ready !== e_ready) begin
        miscompares++;
        $display("FAIL R7 cyc %0d ready=%b exp=%b", n, ready, e_ready);
      end
      if (rd_ok !== e_rd) begin
        miscompares++;
        $display("FAIL R8/R9/R10 cyc %0d rd_ok=%b exp=%b", n, rd_ok, e_rd);
      end
    end
  end

  // ---------------- watchdog ----------------
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog expired after %0d cycles", wd);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int k);
    repeat (k) @(posedge clk);
    #2;
  endtask

  task automatic set_cfg(input bit d, input bit h, input logic [1:0] o,
                         input logic [2:0] l, input logic [2:0] c, input bit s);
    dll_en = d; half = h; odt = o; lat = l; ocd = c; soff = s;
  endtask

  task automatic pulse_req();
    req = 1'b1;
    tick(1);
    req = 1'b0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    // R1, R7: quiet cycles after reset, ready and rd_ok stay low
    tick(4);

    // R4: request held while banks busy, then while clock enable low
    banks_idle = 1'b0;
    set_cfg(1, 1, 2'b10, 3'd3, 3'd0, 0);
    pulse_req();
    tick(5);
    banks_idle = 1'b1;
    cke = 1'b0;
    tick(5);
    cke = 1'b1;
    // R6: second request lands in the spacing window, third is discarded
    tick(1);
    set_cfg(1, 0, 2'b01, 3'd5, 3'd7, 1);
    pulse_req();
    set_cfg(0, 1, 2'b11, 3'd1, 3'd2, 0);
    pulse_req();
    // R8: lockout runs out
    tick(LOCK + 20);

    // R3: field packing under several patterns
    for (int i = 0; i < 8; i++) begin
      set_cfg(1, i[0], 2'(i), 3'(7 - i), 3'(i * 3), i[1]);
      pulse_req();
      tick(3);
    end
    // R5, R6: request offered on every cycle
    for (int i = 0; i < 10; i++) begin
      set_cfg(1, i[1], 2'(i + 1), 3'(i), 3'(i + 2), i[0]);
      pulse_req();
    end
    tick(LOCK + 10);

    // R9: write with DLL off, then back on
    set_cfg(0, 0, 2'b00, 3'd0, 3'd0, 0);
    pulse_req();
    tick(30);
    set_cfg(1, 0, 2'b01, 3'd2, 3'd0, 0);
    pulse_req();
    tick(LOCK + 10);

    // R10: self-refresh drops permission, exit restarts the lockout
    sr_enter = 1'b1;
    tick(1);
    sr_enter = 1'b0;
    tick(12);
    sr_exit = 1'b1;
    tick(1);
    sr_exit = 1'b0;
    tick(LOCK + 10);

    // R9, R10: exit with DLL configured off does not restore permission
    set_cfg(0, 1, 2'b10, 3'd4, 3'd1, 1);
    pulse_req();
    tick(6);
    sr_enter = 1'b1;
    tick(1);
    sr_enter = 1'b0;
    tick(5);
    sr_exit = 1'b1;
    tick(1);
    sr_exit = 1'b0;
    tick(20);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule